// File: doc/BRIEF.md
# Running-Average Power Limiter

The limiter receives one energy sample per clock cycle from a power-estimation source for a single power domain. It keeps two kinds of state from those samples. A 32-bit total-energy counter adds every sample, so software can read the energy spent over any interval. Each of two cap channels keeps an exponentially weighted running sum, and that sum gives an average energy per cycle over a window of 2^k cycles. Every cap has its own limit, its own window exponent and its own enable. Typically one cap holds a short window and tracks temperature, and the other holds a long window and tracks a battery or supply budget.

A cap raises its exceed flag when its running average is strictly above its limit. Any raised flag starts a throttle request, which asks the performance controller to step down. The request stays asserted for a minimum hold time, so the controller does not receive brief pulses. A chip with several domains (package, core plane, uncore plane, memory) places one instance of this block per domain, and each instance has its own settings.

Top module: `power_avg_limiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the energy counter, both exceed flags and the throttle request are zero, and every running sum is zero.
- R2: At each clock edge the energy counter adds the current 16-bit sample. The counter wraps modulo 2^32.
- R3: At each clock edge, cap i updates its running sum S to S - (S >> k) + sample. Here k is the cap's 5-bit window exponent in that cycle: cap 0 uses exponent bits [4:0] and cap 1 uses bits [9:5]. The cap's average is the new S >> k.
- R4: A cap's exceed flag is registered at the same edge as its running sum. It is 1 only when the new average is strictly greater than the cap's 16-bit limit. Cap 0's limit is bits [15:0] and cap 1's limit is bits [31:16]. An average equal to the limit does not raise the flag.
- R5: When a cap's enable bit (bit i of the enable input) is 0 at an edge, that cap's flag is 0 after the edge, whatever its average is.
- R6: The two caps are independent. Each flag depends only on that cap's own enable, limit and exponent, together with the shared sample stream.
- R7: If any exceed flag is 1 in a cycle, the throttle request is 1 in the next cycle.
- R8: After the last cycle t in which a flag was 1, the throttle request stays 1 up to and including cycle t+16. It is 0 from cycle t+17 onward, unless a flag rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 16 | Energy consumed in this cycle |
| cap_en_i | input | 2 | Per-cap enable |
| cap_limit_i | input | 32 | Per-cap average limit, 16 bits each, cap 0 in the low half |
| cap_exp_i | input | 10 | Per-cap window exponent, 5 bits each, cap 0 in the low bits |
| energy_o | output | 32 | Total energy counter |
| exceed_o | output | 2 | Per-cap exceed flags |
| throttle_o | output | 1 | Request for a lower performance level |

## Verification
The assertions assume that the sample, limit, exponent and enable inputs are driven to known values on every cycle after reset. They also assume that these inputs may change on any cycle, including in the middle of a window. The stimulus meets this by changing inputs only away from the active edge and by never leaving a bit undriven. The random exponents stay small, which lets the averages cross their limits within a few cycles. Directed phases then cover equality with a limit, disabled caps, the throttle hold tail and a full 2^32 wrap of the energy counter.

// File: rtl/pl_pkg.sv
package pl_pkg;
    localparam int SAMPLE_W = 16;
    localparam int EXP_W    = 5;
    localparam int ENERGY_W = 32;
    localparam int NCAP     = 2;
    localparam int HOLD     = 16;
endpackage

// File: rtl/pl_energy_acc.sv
module pl_energy_acc #(
    parameter int SAMPLE_W = pl_pkg::SAMPLE_W,
    parameter int ENERGY_W = pl_pkg::ENERGY_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [ENERGY_W-1:0] energy_o
);
    typedef struct packed {
        logic [ENERGY_W-1:0] total;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.total = st_q.total + ENERGY_W'(sample_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign energy_o = st_q.total;

    // R2
    energy_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i != '0) |=> (energy_o != $past(energy_o)));
endmodule

// File: rtl/pl_avg_cap.sv
module pl_avg_cap #(
    parameter int SAMPLE_W = pl_pkg::SAMPLE_W,
    parameter int EXP_W    = pl_pkg::EXP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                en_i,
    input  logic [SAMPLE_W-1:0] limit_i,
    input  logic [EXP_W-1:0]    exp_i,
    output logic                exceed_o
);
    localparam int SUM_W = SAMPLE_W + (1 << EXP_W) - 1;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic             exceed;
    } cap_st_t;

    cap_st_t          st_d, st_q;
    logic [SUM_W-1:0] avg;

    always_comb begin
        st_d        = st_q;
        st_d.sum    = st_q.sum - (st_q.sum >> exp_i) + SUM_W'(sample_i);
        avg         = st_d.sum >> exp_i;
        st_d.exceed = en_i && (avg > SUM_W'(limit_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign exceed_o = st_q.exceed;

    // R5
    off_cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !exceed_o);

    // R4
    equal_not_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_i == '0 && sample_i <= limit_i) |=> !exceed_o);
endmodule

// File: rtl/pl_hold.sv
module pl_hold #(
    parameter int HOLD = pl_pkg::HOLD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(HOLD);

    typedef struct packed {
        logic [CNT_W-1:0] left;
        logic             active;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.active = req_i || (st_q.left != '0);
        if (req_i)                  st_d.left = CNT_W'(HOLD - 1);
        else if (st_q.left != '0)   st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;

    // R7
    req_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> active_o);
endmodule

// File: rtl/power_avg_limiter.sv
module power_avg_limiter #(
    parameter int SAMPLE_W = pl_pkg::SAMPLE_W,
    parameter int EXP_W    = pl_pkg::EXP_W,
    parameter int ENERGY_W = pl_pkg::ENERGY_W,
    parameter int NCAP     = pl_pkg::NCAP,
    parameter int HOLD     = pl_pkg::HOLD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SAMPLE_W-1:0]      sample_i,
    input  logic [NCAP-1:0]          cap_en_i,
    input  logic [NCAP*SAMPLE_W-1:0] cap_limit_i,
    input  logic [NCAP*EXP_W-1:0]    cap_exp_i,
    output logic [ENERGY_W-1:0]      energy_o,
    output logic [NCAP-1:0]          exceed_o,
    output logic                     throttle_o
);
    localparam int QW = $clog2(HOLD) + 1;

    pl_energy_acc #(.SAMPLE_W(SAMPLE_W), .ENERGY_W(ENERGY_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .energy_o(energy_o)
    );

    for (genvar i = 0; i < NCAP; i++) begin : g_cap
        pl_avg_cap #(.SAMPLE_W(SAMPLE_W), .EXP_W(EXP_W)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .sample_i(sample_i),
            .en_i    (cap_en_i[i]),
            .limit_i (cap_limit_i[i*SAMPLE_W +: SAMPLE_W]),
            .exp_i   (cap_exp_i[i*EXP_W +: EXP_W]),
            .exceed_o(exceed_o[i])
        );
    end

    pl_hold #(.HOLD(HOLD)) u_hold (
        .clk(clk), .rst_n(rst_n), .req_i(|exceed_o), .active_o(throttle_o)
    );

    // Checker state: cycles since a flag was last seen, saturating at HOLD.
    logic [QW-1:0] quiet_d, quiet_q;
    always_comb begin
        if (|exceed_o)                 quiet_d = '0;
        else if (quiet_q < QW'(HOLD))  quiet_d = quiet_q + 1'b1;
        else                           quiet_d = quiet_q;
    end
    always_ff @(posedge clk) begin
        if (!rst_n) quiet_q <= QW'(HOLD);
        else        quiet_q <= quiet_d;
    end

    // R8
    throttle_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        throttle_o == (quiet_q < QW'(HOLD)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (energy_o == '0 && exceed_o == '0 && !throttle_o));
endmodule

// File: tb/sim_power_avg_limiter.sv
module sim_power_avg_limiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] sample_i;
    logic [1:0]  cap_en_i;
    logic [31:0] cap_limit_i;
    logic [9:0]  cap_exp_i;
    logic [31:0] energy_o;
    logic [1:0]  exceed_o;
    logic        throttle_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_energy;
    logic [63:0] m_sum [2];
    logic [1:0]  m_flag;
    logic        m_thr;
    int          m_hold;

    always #5 clk = ~clk;

    power_avg_limiter u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .cap_en_i(cap_en_i),
        .cap_limit_i(cap_limit_i), .cap_exp_i(cap_exp_i),
        .energy_o(energy_o), .exceed_o(exceed_o), .throttle_o(throttle_o)
    );

    function automatic logic [63:0] ewma(input logic [63:0] s, input int k,
                                         input logic [15:0] x);
        return s - (s >> k) + 64'(x);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_energy = '0; m_sum[0] = '0; m_sum[1] = '0;
        m_flag = '0; m_thr = 1'b0; m_hold = 0;
    endtask

    task automatic model_step();
        logic nthr;
        int   nhold;
        nthr  = (m_flag != 0) || (m_hold != 0);
        nhold = (m_flag != 0) ? 15 : ((m_hold != 0) ? m_hold - 1 : 0);
        m_energy = m_energy + 32'(sample_i);
        for (int i = 0; i < 2; i++) begin
            int k;
            k = int'(cap_exp_i[i*5 +: 5]);
            m_sum[i]  = ewma(m_sum[i], k, sample_i);
            m_flag[i] = cap_en_i[i] && ((m_sum[i] >> k) > 64'(cap_limit_i[i*16 +: 16]));
        end
        m_thr  = nthr;
        m_hold = nhold;
    endtask

    task automatic compare(input string ftag);
        chk("R2 energy", 64'(energy_o), 64'(m_energy));
        chk({ftag, " exceed"}, 64'(exceed_o), 64'(m_flag));
        chk("R7/R8 throttle", 64'(throttle_o), 64'(m_thr));
    endtask

    task automatic tick(input string ftag);
        model_step();
        @(negedge clk);
        compare(ftag);
    endtask

    task automatic set_caps(input logic [1:0] en, input logic [15:0] l0, input logic [15:0] l1,
                            input logic [4:0] e0, input logic [4:0] e1);
        cap_en_i = en; cap_limit_i = {l1, l0}; cap_exp_i = {e1, e0};
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        rst_n = 1'b0; sample_i = '0;
        set_caps(2'b00, 16'd0, 16'd0, 5'd0, 5'd0);
        model_reset();
        repeat (3) @(negedge clk);
        sample_i = 16'd900;
        @(negedge clk);
        // R1: outputs clear under reset even with a sample present
        chk("R1 energy", 64'(energy_o), 64'd0);
        chk("R1 exceed", 64'(exceed_o), 64'd0);
        chk("R1 throttle", 64'(throttle_o), 64'd0);
        sample_i = '0;
        rst_n = 1'b1;
        tick("R1");
        chk("R1 first energy", 64'(energy_o), 64'd0);

        // R5: caps disabled, large samples, flags stay low
        set_caps(2'b00, 16'd10, 16'd10, 5'd0, 5'd2);
        sample_i = 16'd1000;
        repeat (5) tick("R5");
        chk("R5 disabled flags", 64'(exceed_o), 64'd0);

        // R4: equality with limit does not trip, one above does
        set_caps(2'b11, 16'd500, 16'd60000, 5'd0, 5'd0);
        sample_i = 16'd500;
        tick("R4");
        chk("R4 equal limit", 64'(exceed_o[0]), 64'd0);
        sample_i = 16'd501;
        tick("R4");
        chk("R4 above limit", 64'(exceed_o[0]), 64'd1);

        // R8: throttle tail after the last flag
        sample_i = 16'd0;
        tick("R4");
        chk("R7 throttle after flag", 64'(throttle_o), 64'd1);
        for (int c = 0; c < 20; c++) begin
            tick("R8");
            chk("R8 tail", 64'(throttle_o), (c < 15) ? 64'd1 : 64'd0);
        end

        // R6: same sample, different windows give different flags
        set_caps(2'b11, 16'd50, 16'd50, 5'd0, 5'd4);
        sample_i = 16'd60;
        tick("R6");
        chk("R6 short window", 64'(exceed_o[0]), 64'd1);
        chk("R6 long window", 64'(exceed_o[1]), 64'd0);
        repeat (80) tick("R6");
        chk("R6 long window settles", 64'(exceed_o[1]), 64'd1);

        // R3: random samples and settings
        for (int r = 0; r < 4000; r++) begin
            if (r % 64 == 0)
                set_caps(2'($urandom), 16'($urandom % 2000), 16'($urandom % 2000),
                         5'($urandom % 6), 5'($urandom % 6));
            sample_i = 16'($urandom % 3000);
            tick("R3");
        end

        // R2: counter wrap with maximum samples
        set_caps(2'b00, 16'd0, 16'd0, 5'd0, 5'd31);
        sample_i = 16'hFFFF;
        for (int w = 0; w < 65560; w++) model_step();
        repeat (65559) @(negedge clk);
        @(negedge clk);
        compare("R2");
        chk("R2 wrapped", 64'(energy_o < 32'hFFFF_0000), 64'd1);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule